// File: doc/BRIEF.md
# Selectable Fast Interrupt Router

This block forms the fast-interrupt request vector for a processor core from a wider bank of ordinary interrupt lines. It provides eight fast slots. Slot 0 is a reserved default that never carries a request. Each of slots 1 to 7 has its own select value, held in a register outside this block, that picks one line out of the ordinary bank. The slot then watches that line using the trigger mode configured for the chosen line: level, rising edge or falling edge.

A level slot reports its line directly. An edge slot latches a pending flag, and software clears the flag by writing 1 to the slot's clear bit. When the select value of a slot is changed, that slot's latched flag is dropped, so a change of source cannot leave a false request behind. The flags of all slots are combined into one request that drives an active-low processor pin. The lowest-numbered pending slot is also reported as the active vector.

This lets a few urgent sources, such as debug-channel traffic or a diagnostic serial port, be lifted onto the fast path without rewiring the chip.

Top module: `fast_irq_router`

## Requirements
- R1: While `rst_n` is low and at the first cycle after it rises, with all source lines low, `slot_pend` is all zero, `vec_valid` is 0 and `fiq_n` is 1.
- R2: Bit 0 of `slot_pend` is always 0, even when every source line is high.
- R3: Slot s (1 to 7) uses select field `slot_sel[(s-1)*SEL_W +: SEL_W]`, which names source index n. A value of n at or above NUM_SRC selects a constant-zero line whose trigger mode is level.
- R4: Trigger code 2'b01 (rising edge), read from `src_trig[2n +: 2]`: a 0-to-1 change of the selected line, seen at one clock edge, sets the slot's pending bit after that edge. The bit then stays set after the line falls back to 0.
- R5: Trigger code 2'b10 (falling edge): a 1-to-0 change sets the pending bit after the edge that sees it. A rising change does not set it.
- R6: Trigger code 2'b00 (level), or the spare code 2'b11: the slot's pending bit equals the selected line in the same cycle and is never latched.
- R7: For an edge slot, `pend_clr[s]` = 1 at a clock edge clears the pending bit, and a 0 leaves it set. If a new edge and the clear arrive at the same edge, the bit stays set.
- R8: A change of a slot's select value clears that slot's latched pending bit at the next clock edge. The edge between the old and the new line is not taken as a trigger.
- R9: `fiq_n` is 0 exactly when at least one bit of `slot_pend` is 1.
- R10: When any slot is pending, `vec_valid` is 1 and `vec_id` is the lowest-numbered pending slot. Otherwise `vec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_irq | input | NUM_SRC | Ordinary interrupt lines |
| src_trig | input | 2*NUM_SRC | Trigger mode per line, two bits per line |
| slot_sel | input | (NUM_SLOTS-1)*SEL_W | Select values of slots 1 to NUM_SLOTS-1 |
| pend_clr | input | NUM_SLOTS | Write-1 clear pulses for latched pending bits |
| slot_pend | output | NUM_SLOTS | Pending state of each slot |
| vec_valid | output | 1 | At least one slot is pending |
| vec_id | output | $clog2(NUM_SLOTS) | Lowest-numbered pending slot |
| fiq_n | output | 1 | Active-low combined fast request |

## Verification
The hold and clear properties assume that the trigger mode of a selected line stays put, or moves only between the two edge codes, across the cycle being checked. They also assume that select values change only after reset has been released for a cycle. The directed tasks change trigger codes only while a slot's select value is parked out of range, or before the settling cycle that follows a new selection. Every task returns the block to that parked state before the next one starts.

// File: rtl/fir_pkg.sv
// Package: shared trigger-mode encoding for the fast interrupt router.
// Assumes two bits of mode per ordinary interrupt line.
package fir_pkg;
    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'b00,
        TRIG_RISE  = 2'b01,
        TRIG_FALL  = 2'b10,
        TRIG_SPARE = 2'b11
    } trig_e;
endpackage

// File: rtl/fir_src_mux.sv
// Module: per-slot source selector. Picks one line and its trigger mode
// from the ordinary bank. Assumes out-of-range indexes map to a quiet
// level-mode line.
module fir_src_mux
    import fir_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int SEL_W   = 7
) (
    input  logic [NUM_SRC-1:0]   src_irq,
    input  logic [2*NUM_SRC-1:0] src_trig,
    input  logic [SEL_W-1:0]     sel,
    output logic                 line,
    output trig_e                trig
);
    // Decode the index against every implemented line; no match gives zero.
    always_comb begin
        line = 1'b0;
        trig = TRIG_LEVEL;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (32'(sel) == i) begin
                line = src_irq[i];
                trig = trig_e'(src_trig[2*i +: 2]);
            end
        end
    end
endmodule

// File: rtl/fir_slot_det.sv
// Module: trigger detector of one fast slot. Latches edges, passes
// levels through, and drops its latch when the selection moves.
// Assumes synchronous active-low reset.
module fir_slot_det
    import fir_pkg::*;
#(
    parameter int SEL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line,
    input  trig_e            trig,
    input  logic [SEL_W-1:0] sel,
    input  logic             clr,
    output logic             pend
);
    logic             prev_line;
    logic [SEL_W-1:0] prev_sel;
    logic             edge_q;
    logic             edge_mode;
    logic             hit;

    // Classify the mode and spot a qualifying transition this cycle.
    always_comb begin
        edge_mode = (trig == TRIG_RISE) || (trig == TRIG_FALL);
        hit = ((trig == TRIG_RISE) && line && !prev_line) ||
              ((trig == TRIG_FALL) && !line && prev_line);
    end

    // Track history and update the latched flag: reselect beats set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_line <= 1'b0;
            prev_sel  <= '0;
            edge_q    <= 1'b0;
        end else begin
            prev_line <= line;
            prev_sel  <= sel;
            if ((sel != prev_sel) || !edge_mode) begin
                edge_q <= 1'b0;
            end else if (hit) begin
                edge_q <= 1'b1;
            end else if (clr) begin
                edge_q <= 1'b0;
            end
        end
    end

    // Report the latch in edge modes and the raw line otherwise.
    always_comb pend = edge_mode ? edge_q : line;
endmodule

// File: rtl/fir_prio_enc.sv
// Module: lowest-index-wins encoder over the slot pending bits.
// Assumes NUM_SLOTS is at least 2.
module fir_prio_enc #(
    parameter int NUM_SLOTS = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] req,
    output logic                 valid,
    output logic [SLOT_W-1:0]    id
);
    // Scan downward so the lowest requesting index is the last written.
    always_comb begin
        valid = 1'b0;
        id    = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                id    = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/fast_irq_router.sv
// Module: selectable fast interrupt router. Slot 0 is tied off. Every
// other slot muxes one ordinary line and detects it in that line's mode.
// The slots combine into an active-low request and a lowest-slot vector.
// Assumes select values come from registers held elsewhere.
module fast_irq_router
    import fir_pkg::*;
#(
    parameter int NUM_SRC   = 64,
    parameter int SEL_W     = 7,
    parameter int NUM_SLOTS = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SRC-1:0]             src_irq,
    input  logic [2*NUM_SRC-1:0]           src_trig,
    input  logic [(NUM_SLOTS-1)*SEL_W-1:0] slot_sel,
    input  logic [NUM_SLOTS-1:0]           pend_clr,
    output logic [NUM_SLOTS-1:0]           slot_pend,
    output logic                           vec_valid,
    output logic [SLOT_W-1:0]              vec_id,
    output logic                           fiq_n
);
    // Slot 0 is the reserved default and never requests.
    assign slot_pend[0] = 1'b0;

    generate
        for (genvar s = 1; s < NUM_SLOTS; s++) begin : g_slot
            logic             line_s;
            trig_e            trig_s;
            logic [SEL_W-1:0] sel_s;

            assign sel_s = slot_sel[(s-1)*SEL_W +: SEL_W];

            fir_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
                .src_irq (src_irq),
                .src_trig(src_trig),
                .sel     (sel_s),
                .line    (line_s),
                .trig    (trig_s)
            );

            fir_slot_det #(.SEL_W(SEL_W)) u_det (
                .clk  (clk),
                .rst_n(rst_n),
                .line (line_s),
                .trig (trig_s),
                .sel  (sel_s),
                .clr  (pend_clr[s]),
                .pend (slot_pend[s])
            );
        end
    endgenerate

    fir_prio_enc #(.NUM_SLOTS(NUM_SLOTS)) u_enc (
        .req  (slot_pend),
        .valid(vec_valid),
        .id   (vec_id)
    );

    // Merge all slots into the inverted processor request.
    always_comb fiq_n = ~(|slot_pend);
endmodule

// File: rtl/fir_checker.sv
// Module: property checker for the fast interrupt router, attached by bind.
// Assumes trigger modes of a selected line do not flip between edge and
// level within the checked cycle pair.
module fir_checker #(
    parameter int NUM_SRC   = 64,
    parameter int SEL_W     = 7,
    parameter int NUM_SLOTS = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [2*NUM_SRC-1:0]           src_trig,
    input logic [(NUM_SLOTS-1)*SEL_W-1:0] slot_sel,
    input logic [NUM_SLOTS-1:0]           pend_clr,
    input logic [NUM_SLOTS-1:0]           slot_pend,
    input logic                           vec_valid,
    input logic [SLOT_W-1:0]              vec_id,
    input logic                           fiq_n
);
    logic past_ok;

    // Mark cycles whose previous sample lies after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_PIN_MATCHES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        ((!fiq_n) == vec_valid)); // R9

    AST_VEC_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (slot_pend[vec_id] &&
        ((slot_pend & ((NUM_SLOTS'(1) << vec_id) - NUM_SLOTS'(1))) == '0))); // R10

    generate
        for (genvar s = 1; s < NUM_SLOTS; s++) begin : g_chk
            logic [SEL_W-1:0] sel_s;
            logic             edge_s;

            assign sel_s = slot_sel[(s-1)*SEL_W +: SEL_W];

            // Work out whether the selected line uses an edge mode.
            always_comb begin
                edge_s = 1'b0;
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (32'(sel_s) == i) begin
                        edge_s = (src_trig[2*i +: 2] == 2'b01) ||
                                 (src_trig[2*i +: 2] == 2'b10);
                    end
                end
            end

            AST_RESELECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && !$stable(sel_s)) |=> (!edge_s || !slot_pend[s])); // R8

            AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && edge_s && slot_pend[s] && !pend_clr[s] && $stable(sel_s))
                |=> (!edge_s || slot_pend[s])); // R7
        end
    endgenerate
endmodule

bind fast_irq_router fir_checker #(
    .NUM_SRC  (NUM_SRC),
    .SEL_W    (SEL_W),
    .NUM_SLOTS(NUM_SLOTS)
) u_fir_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_trig (src_trig),
    .slot_sel (slot_sel),
    .pend_clr (pend_clr),
    .slot_pend(slot_pend),
    .vec_valid(vec_valid),
    .vec_id   (vec_id),
    .fiq_n    (fiq_n)
);

// File: tb/fast_irq_router_test.sv
// Directed bench for the fast interrupt router: one task per scenario.
module fast_irq_router_test;
    localparam int NSRC  = 64;
    localparam int SW    = 7;
    localparam int NSLOT = 8;
    localparam int IDW   = $clog2(NSLOT);
    localparam logic [SW-1:0] PARK = 7'd127;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [NSRC-1:0]           src_irq = '0;
    logic [2*NSRC-1:0]         src_trig = '0;
    logic [(NSLOT-1)*SW-1:0]   slot_sel = '0;
    logic [NSLOT-1:0]          pend_clr = '0;
    logic [NSLOT-1:0]          slot_pend;
    logic                      vec_valid;
    logic [IDW-1:0]            vec_id;
    logic                      fiq_n;

    int checks = 0;
    int errors = 0;

    fast_irq_router #(.NUM_SRC(NSRC), .SEL_W(SW), .NUM_SLOTS(NSLOT)) uut (
        .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .src_trig(src_trig),
        .slot_sel(slot_sel), .pend_clr(pend_clr), .slot_pend(slot_pend),
        .vec_valid(vec_valid), .vec_id(vec_id), .fiq_n(fiq_n)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic drive_edge();
        @(negedge clk);
    endtask

    task automatic set_sel(input int slot, input logic [SW-1:0] v);
        slot_sel[(slot-1)*SW +: SW] = v;
    endtask

    task automatic set_trig(input int src, input logic [1:0] code);
        src_trig[2*src +: 2] = code;
    endtask

    task automatic park_all();
        drive_edge();
        src_irq = '0;
        src_trig = '0;
        pend_clr = '0;
        for (int s = 1; s < NSLOT; s++) set_sel(s, PARK);
        tick();
        tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        check("R1 pend in reset", 32'(slot_pend), 32'h0);
        check("R1 fiq_n in reset", 32'(fiq_n), 32'h1);
        drive_edge();
        rst_n = 1'b1;
        tick();
        check("R1 vec_valid after reset", 32'(vec_valid), 32'h0);
        check("R1 pend after reset", 32'(slot_pend), 32'h0);
    endtask

    task automatic t_slot0();
        drive_edge();
        for (int s = 1; s < NSLOT; s++) set_sel(s, 7'd0);
        src_irq = '1;
        #1;
        check("R2 slot0 low, others level high", 32'(slot_pend), 32'hFE);
        park_all();
    endtask

    task automatic t_select();
        drive_edge();
        set_sel(3, 7'd10);
        src_irq[10] = 1'b1;
        #1;
        check("R3 slot3 picks line 10", 32'(slot_pend), 32'h08);
        drive_edge();
        set_sel(3, 7'd64);
        src_irq = '1;
        #1;
        check("R3 out of range index is zero", 32'(slot_pend), 32'h00);
        park_all();
    endtask

    task automatic t_rise();
        drive_edge();
        set_trig(20, 2'b01);
        set_sel(2, 7'd20);
        tick();
        drive_edge();
        src_irq[20] = 1'b1;
        #1;
        check("R4 not yet latched before edge", 32'(slot_pend[2]), 32'h0);
        tick();
        check("R4 rise latched", 32'(slot_pend[2]), 32'h1);
        drive_edge();
        src_irq[20] = 1'b0;
        tick();
        check("R4 stays after line falls", 32'(slot_pend[2]), 32'h1);
        drive_edge();
        pend_clr[6] = 1'b1;
        tick();
        check("R7 other clear bit no effect", 32'(slot_pend[2]), 32'h1);
        drive_edge();
        pend_clr = '0;
        pend_clr[2] = 1'b1;
        tick();
        drive_edge();
        pend_clr = '0;
        #1;
        check("R7 write-1 clears", 32'(slot_pend[2]), 32'h0);
        src_irq[20] = 1'b1;
        pend_clr[2] = 1'b1;
        tick();
        drive_edge();
        pend_clr = '0;
        #1;
        check("R7 set beats clear", 32'(slot_pend[2]), 32'h1);
        park_all();
    endtask

    task automatic t_fall();
        drive_edge();
        set_trig(30, 2'b10);
        set_sel(4, 7'd30);
        tick();
        drive_edge();
        src_irq[30] = 1'b1;
        tick();
        tick();
        check("R5 rise ignored", 32'(slot_pend[4]), 32'h0);
        drive_edge();
        src_irq[30] = 1'b0;
        tick();
        check("R5 fall latched", 32'(slot_pend[4]), 32'h1);
        park_all();
    endtask

    task automatic t_level();
        drive_edge();
        set_sel(5, 7'd40);
        src_irq[40] = 1'b1;
        #1;
        check("R6 level follows high", 32'(slot_pend[5]), 32'h1);
        drive_edge();
        src_irq[40] = 1'b0;
        #1;
        check("R6 level follows low", 32'(slot_pend[5]), 32'h0);
        drive_edge();
        set_trig(40, 2'b11);
        src_irq[40] = 1'b1;
        #1;
        check("R6 spare code acts as level", 32'(slot_pend[5]), 32'h1);
        drive_edge();
        src_irq[40] = 1'b0;
        #1;
        check("R6 spare code not latched", 32'(slot_pend[5]), 32'h0);
        park_all();
    endtask

    task automatic t_reselect();
        drive_edge();
        set_trig(20, 2'b01);
        set_trig(21, 2'b01);
        set_sel(2, 7'd20);
        tick();
        drive_edge();
        src_irq[20] = 1'b1;
        src_irq[21] = 1'b1;
        tick();
        check("R8 setup latched", 32'(slot_pend[2]), 32'h1);
        drive_edge();
        set_sel(2, 7'd21);
        tick();
        check("R8 reselect clears", 32'(slot_pend[2]), 32'h0);
        tick();
        check("R8 no spurious edge", 32'(slot_pend[2]), 32'h0);
        park_all();
    endtask

    task automatic t_vector();
        drive_edge();
        set_sel(3, 7'd10);
        set_sel(5, 7'd40);
        src_irq[10] = 1'b1;
        src_irq[40] = 1'b1;
        #1;
        check("R10 lowest id", 32'(vec_id), 32'd3);
        check("R9 pin low when pending", 32'(fiq_n), 32'h0);
        drive_edge();
        src_irq[10] = 1'b0;
        #1;
        check("R10 next lowest", 32'(vec_id), 32'd5);
        drive_edge();
        set_sel(1, 7'd50);
        set_sel(7, 7'd50);
        src_irq[50] = 1'b1;
        #1;
        check("R10 slot1 over slot7", 32'(vec_id), 32'd1);
        drive_edge();
        src_irq = '0;
        #1;
        check("R10 vec_valid idle", 32'(vec_valid), 32'h0);
        check("R9 pin high when idle", 32'(fiq_n), 32'h1);
        park_all();
    endtask

    initial begin
        for (int s = 1; s < NSLOT; s++) set_sel(s, PARK);
        t_reset();
        park_all();
        t_slot0();
        t_select();
        t_rise();
        t_fall();
        t_level();
        t_reselect();
        t_vector();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule